// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the receive side of a stereo serial audio link in which the block is always the clock slave. The sending device supplies a bit clock, a word clock that marks the two channel halves of each frame, and one data line. The block runs entirely on the supplied bit clock. It turns the serial stream into one parallel word per channel and raises a one-cycle strobe when a complete left-plus-right frame is available.

A 3-bit format code selects where in each half-frame the sample sits: aligned to the end of the half (three word widths), aligned to its start, or delayed by one bit clock as in I2S. Because end-aligned data can only be located once the half-frame is over, the block keeps a running window of the most recent bits and reads it when the word clock toggles. The format code is taken only on leaving power-down, so it cannot change underneath a running stream. Every sample leaves the block as a 24-bit two's complement word with the received bits at the top and zeros below them.

Top module: `ser_audio_rx`

## Requirements
- R1: While `pwr_dn_ni` is low all outputs are zero, and `valid_o` stays low after release until the first complete frame has been received.
- R2: Codes 000, 001 and 100 select end-aligned data of 16, 20 and 24 bits: the sample is the last N bits of the half-frame, MSB first, placed in bits 23 down to 24-N of the output with the bits below cleared; earlier slots are ignored.
- R3: Code 010 selects start-aligned 20-bit data: the MSB is the bit sampled on the first bit-clock rising edge at which the new word-clock level is seen (slot 0); when a half-frame has fewer than 20 slots only its bits are kept at the top and the rest are zero.
- R4: Code 011 selects I2S: the MSB is in slot 1, 20 bits are captured into bits 23..4, and the left channel is the half with the word clock low.
- R5: In codes other than 011 the left channel is the half-frame with the word clock high.
- R6: `valid_o` is high for exactly one bit-clock cycle per stereo frame, starting after the rising edge at which slot 0 of the following left half is sampled; `left_o` and `right_o` change only together with that strobe and hold otherwise.
- R7: The format code is captured on the first bit-clock rising edge after `pwr_dn_ni` rises; later changes of `fmt_i` have no effect until the next power-down.
- R8: Half-frame length is taken from the word clock alone, so 16, 20, 24 and 32 bit clocks per channel all decode correctly.
- R9: The partial half in progress at release is discarded, and a right half with no preceding left half in the same frame produces no strobe.
- R10: Codes 101, 110 and 111 decode as 16-bit end-aligned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock from the sender; data and word clock are sampled on its rising edge |
| pwr_dn_ni | input | 1 | Active-low power-down; asynchronous reset of all state |
| lrck_i | input | 1 | Word clock selecting the channel half |
| sdat_i | input | 1 | Serial data, MSB first, two's complement |
| fmt_i | input | 3 | Framing code, taken on release from power-down |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a new stereo frame |

## Verification
The assertions take for granted that every half-frame spans at least two bit clocks and that the word clock and data change only between rising bit-clock edges, as the sender guarantees. The assertion on the channel of the strobe also takes the captured format as fixed, which holds because power-down is the only way to load it. The stimulus drives word clock and data on the falling edge, keeps every half at 16 to 32 slots, and gives I2S halves at least 24 slots so the full 20-bit window lies inside one half.

// File: rtl/ser_audio_rx_pkg.sv
package ser_audio_rx_pkg;

  // Framing codes; the numeric values are the external encoding.
  localparam logic [2:0] FMT_TAIL16 = 3'd0;
  localparam logic [2:0] FMT_TAIL20 = 3'd1;
  localparam logic [2:0] FMT_HEAD20 = 3'd2;
  localparam logic [2:0] FMT_I2S20  = 3'd3;
  localparam logic [2:0] FMT_TAIL24 = 3'd4;

  // Width of end-aligned data; reserved codes fall back to 16 bits.
  function automatic int tail_bits(logic [2:0] f);
    case (f)
      FMT_TAIL20: return 20;
      FMT_TAIL24: return 24;
      default:    return 16;
    endcase
  endfunction

  function automatic logic is_head(logic [2:0] f);
    return (f == FMT_HEAD20) || (f == FMT_I2S20);
  endfunction

endpackage

// File: rtl/ser_audio_rx_frame.sv
module ser_audio_rx_frame #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_i,
  input  logic             left_low_i,
  output logic             armed_o,
  output logic             edge_o,
  output logic             done_o,
  output logic             done_left_o,
  output logic [CNT_W-1:0] slot_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             armed_q, armed_d;
  logic             lr_q, lr_d;
  logic             started_q, started_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    edge_o      = armed_q && (lrck_i != lr_q);
    slot_o      = edge_o ? '0 : cnt_q;
    done_o      = edge_o && started_q;
    done_left_o = left_low_i ? !lr_q : lr_q;
    armed_o     = armed_q;

    armed_d   = 1'b1;
    lr_d      = lrck_i;
    started_d = started_q | edge_o;
    if (edge_o)               cnt_d = CNT_ONE;
    else if (cnt_q == CNT_MAX) cnt_d = CNT_MAX;
    else                       cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      lr_q      <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      armed_q   <= armed_d;
      lr_q      <= lr_d;
      started_q <= started_d;
      cnt_q     <= cnt_d;
    end
  end

  // A half can only complete once the half before it was opened by an edge.
  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(armed_o)); // R9

endmodule

// File: rtl/ser_audio_rx_cap.sv
module ser_audio_rx_cap
  import ser_audio_rx_pkg::*;
#(
  parameter int OUT_W  = 24,
  parameter int HEAD_W = 20,
  parameter int CNT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdat_i,
  input  logic [2:0]       fmt_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] slot_i,
  output logic [OUT_W-1:0] word_o
);

  localparam int HEAD_PAD = OUT_W - HEAD_W;

  logic [OUT_W-1:0]  tail_q, tail_d;
  logic [HEAD_W-1:0] head_q, head_d;
  logic [CNT_W-1:0]  start;
  logic [CNT_W-1:0]  rel;
  logic              win;

  // Running window: at a word-clock edge it still holds the previous half's tail.
  always_comb begin
    tail_d = {tail_q[OUT_W-2:0], sdat_i};
  end

  // Start-aligned capture: slot-indexed writes into a window cleared at each edge.
  always_comb begin
    start  = (fmt_i == FMT_I2S20) ? CNT_W'(1) : '0;
    rel    = slot_i - start;
    win    = (slot_i >= start) && (rel < CNT_W'(HEAD_W));
    head_d = edge_i ? '0 : head_q;
    for (int b = 0; b < HEAD_W; b++) begin
      if (win && (rel == CNT_W'(HEAD_W - 1 - b))) head_d[b] = sdat_i;
    end
  end

  always_comb begin
    if (is_head(fmt_i)) word_o = {head_q, {HEAD_PAD{1'b0}}};
    else                word_o = tail_q << (OUT_W - tail_bits(fmt_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
      head_q <= '0;
    end else begin
      tail_q <= tail_d;
      head_q <= head_d;
    end
  end

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import ser_audio_rx_pkg::*;
#(
  parameter int OUT_W  = 24,
  parameter int HEAD_W = 20,
  parameter int CNT_W  = 6
) (
  input  logic             bclk_i,
  input  logic             pwr_dn_ni,
  input  logic             lrck_i,
  input  logic             sdat_i,
  input  logic [2:0]       fmt_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);

  logic             armed, edge_det, done, done_left;
  logic [CNT_W-1:0] slot;
  logic [OUT_W-1:0] word;

  logic [2:0]       fmt_q, fmt_d;
  logic [OUT_W-1:0] hold_q, hold_d;
  logic             have_left_q, have_left_d;
  logic [OUT_W-1:0] left_q, left_d, right_q, right_d;
  logic             valid_q, valid_d;

  ser_audio_rx_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i       (bclk_i),
    .rst_ni      (pwr_dn_ni),
    .lrck_i      (lrck_i),
    .left_low_i  (fmt_q == FMT_I2S20),
    .armed_o     (armed),
    .edge_o      (edge_det),
    .done_o      (done),
    .done_left_o (done_left),
    .slot_o      (slot)
  );

  ser_audio_rx_cap #(.OUT_W(OUT_W), .HEAD_W(HEAD_W), .CNT_W(CNT_W)) u_cap (
    .clk_i  (bclk_i),
    .rst_ni (pwr_dn_ni),
    .sdat_i (sdat_i),
    .fmt_i  (fmt_q),
    .edge_i (edge_det),
    .slot_i (slot),
    .word_o (word)
  );

  always_comb begin
    fmt_d       = armed ? fmt_q : fmt_i;
    hold_d      = hold_q;
    have_left_d = have_left_q;
    left_d      = left_q;
    right_d     = right_q;
    valid_d     = 1'b0;
    if (done && done_left) begin
      hold_d      = word;
      have_left_d = 1'b1;
    end else if (done && have_left_q) begin
      left_d      = hold_q;
      right_d     = word;
      valid_d     = 1'b1;
      have_left_d = 1'b0;
    end
  end

  always_ff @(posedge bclk_i or negedge pwr_dn_ni) begin
    if (!pwr_dn_ni) begin
      fmt_q       <= '0;
      hold_q      <= '0;
      have_left_q <= 1'b0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
    end else begin
      fmt_q       <= fmt_d;
      hold_q      <= hold_d;
      have_left_q <= have_left_d;
      left_q      <= left_d;
      right_q     <= right_d;
      valid_q     <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge bclk_i) disable iff (!pwr_dn_ni)
    valid_o |=> !valid_o); // R6
  AST_OUT_HOLD: assert property (@(posedge bclk_i) disable iff (!pwr_dn_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R6
  AST_FMT_FROZEN: assert property (@(posedge bclk_i) disable iff (!pwr_dn_ni)
    armed |=> $stable(fmt_q)); // R7
  AST_LEFT_START: assert property (@(posedge bclk_i) disable iff (!pwr_dn_ni)
    valid_o |-> ($past(lrck_i) == (fmt_q != FMT_I2S20))); // R5

endmodule

// File: tb/ser_audio_rx_bench.sv
module ser_audio_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lrck, sdat;
  logic [2:0]  fmt;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  always #4 clk = ~clk;

  ser_audio_rx u_ser_audio_rx (
    .bclk_i    (clk),
    .pwr_dn_ni (rst_n),
    .lrck_i    (lrck),
    .sdat_i    (sdat),
    .fmt_i     (fmt),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 end-aligned, 1 start-aligned, 2 I2S
  function automatic bit slot_bit(int kind, int w, int hlen, int s, logic [23:0] d);
    bit junk = s[0] ^ s[2];
    if (kind == 0) return (s >= hlen - w) ? d[hlen-1-s] : junk;
    if (kind == 1) return (s < w) ? d[w-1-s] : junk;
    return (s >= 1 && s <= w) ? d[w-s] : junk;
  endfunction

  function automatic logic [23:0] expect_word(int kind, int w, int hlen, logic [23:0] d);
    int n;
    if (kind == 0) return d << (24 - w);
    n = hlen - ((kind == 2) ? 1 : 0);
    if (n > 20) n = 20;
    return {d[19:0], 4'b0} & ~((24'h1 << (24 - n)) - 24'h1);
  endfunction

  task automatic drive_half(bit lvl, int kind, int w, int hlen, logic [23:0] d);
    for (int s = 0; s < hlen; s++) begin
      @(negedge clk);
      lrck = lvl;
      sdat = slot_bit(kind, w, hlen, s, d);
    end
  endtask

  task automatic frame(string req, int kind, int w, int hlen, bit left_lvl,
                       logic [23:0] dl, logic [23:0] dr);
    logic [23:0] m = (24'h1 << w) - 24'h1;
    exp_q.push_back({expect_word(kind, w, hlen, dl & m), expect_word(kind, w, hlen, dr & m)});
    tag_q.push_back(req);
    drive_half(left_lvl, kind, w, hlen, dl & m);
    drive_half(!left_lvl, kind, w, hlen, dr & m);
  endtask

  task automatic start_stream(logic [2:0] code, bit pre_lvl);
    @(negedge clk);
    rst_n = 1'b0;
    fmt   = code;
    lrck  = pre_lvl;
    sdat  = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {valid_o, left_o, right_o}, 49'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {valid_o, left_o, right_o}, 49'd0);
  endtask

  task automatic end_stream(string req, bit left_lvl);
    drive_half(left_lvl, 0, 16, 8, 24'h0);
    repeat (4) @(negedge clk);
    check(req, 48'(exp_q.size()), 48'd0);
  endtask

  function automatic logic [23:0] pat(int k);
    return 24'((32'h9E3779B9 * (k + 1)) ^ (k << 7));
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && valid_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6 actual=unexpected strobe %h_%h expected=no strobe", left_o, right_o);
      end else begin
        check(tag_q.pop_front(), {left_o, right_o}, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lrck  = 1'b0;
    sdat  = 1'b0;
    fmt   = 3'd0;

    // R2 R8: 16-bit end-aligned, 16 and 32 slots
    start_stream(3'b000, 1'b0);
    frame("R2", 0, 16, 16, 1'b1, 24'h8000, 24'h7FFF);
    frame("R8", 0, 16, 32, 1'b1, pat(1), pat(2));
    frame("R2", 0, 16, 16, 1'b1, 24'hFFFF, 24'h0001);
    end_stream("R6", 1'b1);

    // R2 R8: 20-bit end-aligned
    start_stream(3'b001, 1'b0);
    frame("R2", 0, 20, 20, 1'b1, pat(3), pat(4));
    frame("R8", 0, 20, 32, 1'b1, 24'h80000, 24'h7FFFF);
    end_stream("R6", 1'b1);

    // R2 R8: 24-bit end-aligned
    start_stream(3'b100, 1'b0);
    frame("R2", 0, 24, 24, 1'b1, 24'h800000, 24'h7FFFFF);
    frame("R8", 0, 24, 32, 1'b1, pat(5), pat(6));
    end_stream("R6", 1'b1);

    // R3 R5 R8: start-aligned 20-bit, halves of 16, 20 and 32 slots
    start_stream(3'b010, 1'b0);
    frame("R3", 0 + 1, 20, 16, 1'b1, pat(7), pat(8));
    frame("R5", 1, 20, 20, 1'b1, 24'h80000, 24'h00001);
    frame("R8", 1, 20, 32, 1'b1, pat(9), pat(10));
    end_stream("R6", 1'b1);

    // R4: I2S, left with word clock low
    start_stream(3'b011, 1'b1);
    frame("R4", 2, 20, 24, 1'b0, pat(11), pat(12));
    frame("R4", 2, 20, 32, 1'b0, 24'hFFFFF, 24'h80000);
    end_stream("R6", 1'b0);

    // R10: reserved code behaves as 16-bit end-aligned
    start_stream(3'b111, 1'b0);
    frame("R10", 0, 16, 32, 1'b1, pat(13), pat(14));
    end_stream("R10", 1'b1);

    // R7: format change while running is ignored
    start_stream(3'b001, 1'b0);
    frame("R7", 0, 20, 32, 1'b1, pat(15), pat(16));
    fmt = 3'b010;
    frame("R7", 0, 20, 32, 1'b1, pat(17), pat(18));
    fmt = 3'b011;
    frame("R7", 0, 20, 24, 1'b1, pat(19), pat(20));
    end_stream("R7", 1'b1);

    // R9: partial left half at release, then a lone right half
    start_stream(3'b000, 1'b1);
    drive_half(1'b0, 0, 16, 32, 24'h1234);
    frame("R9", 0, 16, 32, 1'b1, pat(21), pat(22));
    end_stream("R9", 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule